// File: doc/BRIEF.md
# Segmented Core Register Window

This block sits between a host that sees only a 2 KB register window and a backplane on which each core owns a 4 KB register space. Software picks the target core and the half of its space by writing a small bank of byte-wide configuration registers over a dedicated configuration port. Each host access through the window is then turned into one 32-bit backplane request. The block forwards that request, waits for the backplane answer and returns the answer to the host.

The same bank holds two core control bytes. A plain select pin chooses which of the two drives the core reset, interrupt-enable and function-enable outputs. It also decides whether the core interrupt reaches the host.

Host requests and responses, and backplane requests, use valid/ready handshakes. A request is offered with valid high and stays unchanged until ready is seen high at a clock edge. The block carries one transaction at a time: `host_req_ready` is high only while nothing is in flight. A host response is held until `host_rsp_ready` takes it. The backplane answer is a single-cycle `bp_rsp_valid` pulse that cannot be stalled. It is taken only in a cycle after the backplane request has been accepted.

Top module: `seg_core_window`

## Requirements
- R1: While reset is asserted and right after it, both control bytes read 0x80, the three core-select bytes and the segment bit read 0, `core_reset` is 1, and `core_irq_en` and `core_func_en` are 0.
- R2: A configuration write lands at these byte offsets: primary control 0x00, alternate control 0x80, select byte 0 at 0x2E, select byte 1 at 0x30, select byte 2 at 0x32, segment at 0x34. Select byte 0 keeps only data bits 3:0 and the segment keeps only bit 0; both read back zero-extended. The other offsets ignore writes and read back 0. `cfg_rdata` shows the register at `cfg_addr` in the same cycle.
- R3: The backplane address of an accepted host request with offset below 0x800 is {select2[7:0], select1[7:0], select0[3:0], segment, offset[10:0]}.
- R4: A host request with offset 0x800 or above never produces a backplane request. Its host response carries data 0 and is offered in the cycle after acceptance.
- R5: `host_req_ready` is high only when no transaction is in flight, and it returns high in the cycle after the host response is taken.
- R6: `bp_req_valid` rises in the cycle after an in-window request is accepted. Address, write flag and write data stay stable until `bp_req_ready` is seen, and `bp_req_valid` falls in the following cycle.
- R7: Once the backplane answer arrives, `host_rsp_valid` is offered in the next cycle and held with stable data until `host_rsp_ready`. The data is the backplane read data for a read and 0 for a write.
- R8: With `sel_alt_ctl` low the primary control byte drives the outputs, and with it high the alternate byte does. Bit 7 drives `core_reset`, bit 2 drives `core_irq_en` and bit 0 drives `core_func_en`.
- R9: `host_irq` is high exactly when `core_irq_in` is high and the selected control byte has both bit 2 and bit 0 set.
- R10: A `bp_rsp_valid` pulse outside the wait-for-answer phase is ignored: no host response results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data at `cfg_addr` |
| sel_alt_ctl | input | 1 | 1 selects the alternate control byte |
| host_req_valid | input | 1 | Host request offered |
| host_req_ready | output | 1 | Block accepts a host request |
| host_req_write | input | 1 | 1 for write, 0 for read |
| host_req_off | input | 12 | Host window byte offset |
| host_req_wdata | input | 32 | Host write data |
| host_rsp_valid | output | 1 | Host response offered |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_rdata | output | 32 | Host response data |
| bp_req_valid | output | 1 | Backplane request offered |
| bp_req_ready | input | 1 | Backplane accepts the request |
| bp_req_write | output | 1 | Backplane write flag |
| bp_req_addr | output | 32 | Backplane byte address |
| bp_req_wdata | output | 32 | Backplane write data |
| bp_rsp_valid | input | 1 | Backplane answer pulse |
| bp_rsp_rdata | input | 32 | Backplane answer data |
| core_irq_in | input | 1 | Interrupt from the core |
| host_irq | output | 1 | Interrupt forwarded to the host |
| core_reset | output | 1 | Core held in reset |
| core_irq_en | output | 1 | Core interrupt enabled |
| core_func_en | output | 1 | Core function enabled |

## Verification
The assertions assume that the host keeps a request stable while `host_req_ready` is low. They also assume that the backplane answers a request only after accepting it, so the answer pulse never coincides with the request handshake. The stimulus keeps to this. Each host transaction is driven by one sequential task that raises `bp_req_ready` first and pulses `bp_rsp_valid` at least one cycle later. The only pulses sent outside the wait-for-answer phase are deliberate ones that test R10. All inputs change at the falling edge, so no assumed relation is broken at a sampling edge.

// File: rtl/segwin_pkg.sv
package segwin_pkg;

  localparam int CFG_AW   = 8;
  localparam int CFG_DW   = 8;
  localparam int NUM_SEL  = 3;

  localparam logic [CFG_AW-1:0] OFF_CTL  = 8'h00;
  localparam logic [CFG_AW-1:0] OFF_ALT  = 8'h80;
  localparam logic [CFG_AW-1:0] OFF_SEL0 = 8'h2E;
  localparam logic [CFG_AW-1:0] OFF_SEG  = 8'h34;

  localparam int CTL_RST_BIT  = 7;
  localparam int CTL_IRQ_BIT  = 2;
  localparam int CTL_FUNC_BIT = 0;
  localparam logic [CFG_DW-1:0] CTL_RESET_VAL = 8'h80;

  // offset of select byte i, spaced two bytes apart
  function automatic logic [CFG_AW-1:0] sel_offset(input int i);
    return OFF_SEL0 + CFG_AW'(2 * i);
  endfunction

  // bits each select byte actually stores
  function automatic logic [CFG_DW-1:0] sel_mask(input int i);
    return (i == 0) ? 8'h0F : 8'hFF;
  endfunction

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ISSUE = 2'd1,
    TX_WAIT  = 2'd2,
    TX_RESP  = 2'd3
  } txn_state_e;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] mid;
    logic [3:0] lo;
    logic       seg;
  } win_base_t;

endpackage

// File: rtl/segwin_cfg_regs.sv
module segwin_cfg_regs
  import segwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic [CFG_DW-1:0] ctl_q,
  output logic [CFG_DW-1:0] alt_q,
  output win_base_t         base
);

  logic [CFG_DW-1:0] sel_q [NUM_SEL];
  logic              seg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET_VAL;
      alt_q <= CTL_RESET_VAL;
      seg_q <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_addr == OFF_CTL) ctl_q <= cfg_wdata;
      if (cfg_addr == OFF_ALT) alt_q <= cfg_wdata;
      if (cfg_addr == OFF_SEG) seg_q <= cfg_wdata[0];
    end
  end

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    localparam logic [CFG_AW-1:0] MY_OFF  = sel_offset(i);
    localparam logic [CFG_DW-1:0] MY_MASK = sel_mask(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_q[i] <= '0;
      else if (cfg_wr && cfg_addr == MY_OFF)
        sel_q[i] <= cfg_wdata & MY_MASK;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == OFF_CTL) cfg_rdata = ctl_q;
    if (cfg_addr == OFF_ALT) cfg_rdata = alt_q;
    if (cfg_addr == OFF_SEG) cfg_rdata = {{(CFG_DW-1){1'b0}}, seg_q};
    for (int i = 0; i < NUM_SEL; i++) begin
      if (cfg_addr == sel_offset(i)) cfg_rdata = sel_q[i];
    end
  end

  assign base.hi  = sel_q[2];
  assign base.mid = sel_q[1];
  assign base.lo  = sel_q[0][3:0];
  assign base.seg = seg_q;

endmodule

// File: rtl/segwin_xlate.sv
module segwin_xlate
  import segwin_pkg::*;
#(
  parameter int HOST_OFF_W = 12,
  parameter int WIN_W      = 11,
  parameter int BP_AW      = 32
) (
  input  win_base_t             base,
  input  logic [HOST_OFF_W-1:0] off,
  output logic [BP_AW-1:0]      bp_addr,
  output logic                  in_window
);

  localparam int BASE_W = $bits(win_base_t);
  localparam int HI_W   = HOST_OFF_W - WIN_W;

  assign in_window = (off[HOST_OFF_W-1:WIN_W] == {HI_W{1'b0}});
  assign bp_addr   = BP_AW'({base, off[WIN_W-1:0]});

  initial begin
    if (BASE_W + WIN_W != BP_AW)
      $display("segwin_xlate: base and window widths do not fill the address");
  end

endmodule

// File: rtl/segwin_txn_fsm.sv
module segwin_txn_fsm
  import segwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BP_AW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [DATA_W-1:0] host_req_wdata,
  input  logic              in_window,
  input  logic [BP_AW-1:0]  xl_addr,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              bp_req_valid,
  input  logic              bp_req_ready,
  output logic              bp_req_write,
  output logic [BP_AW-1:0]  bp_req_addr,
  output logic [DATA_W-1:0] bp_req_wdata,
  input  logic              bp_rsp_valid,
  input  logic [DATA_W-1:0] bp_rsp_rdata
);

  txn_state_e        state_q;
  logic              write_q;
  logic [BP_AW-1:0]  addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (host_req_valid) begin
            write_q <= host_req_write;
            addr_q  <= xl_addr;
            wdata_q <= host_req_wdata;
            if (in_window) begin
              state_q <= TX_ISSUE;
            end else begin
              rdata_q <= '0;
              state_q <= TX_RESP;
            end
          end
        end
        TX_ISSUE: begin
          if (bp_req_ready) state_q <= TX_WAIT;
        end
        TX_WAIT: begin
          if (bp_rsp_valid) begin
            rdata_q <= write_q ? '0 : bp_rsp_rdata;
            state_q <= TX_RESP;
          end
        end
        TX_RESP: begin
          if (host_rsp_ready) state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign host_req_ready = (state_q == TX_IDLE);
  assign bp_req_valid   = (state_q == TX_ISSUE);
  assign host_rsp_valid = (state_q == TX_RESP);
  assign bp_req_write   = write_q;
  assign bp_req_addr    = addr_q;
  assign bp_req_wdata   = wdata_q;
  assign host_rsp_rdata = rdata_q;

endmodule

// File: rtl/segwin_ctl_out.sv
module segwin_ctl_out
  import segwin_pkg::*;
(
  input  logic [CFG_DW-1:0] ctl_q,
  input  logic [CFG_DW-1:0] alt_q,
  input  logic              sel_alt,
  input  logic              core_irq_in,
  output logic              core_reset,
  output logic              core_irq_en,
  output logic              core_func_en,
  output logic              host_irq
);

  logic [CFG_DW-1:0] active;

  assign active       = sel_alt ? alt_q : ctl_q;
  assign core_reset   = active[CTL_RST_BIT];
  assign core_irq_en  = active[CTL_IRQ_BIT];
  assign core_func_en = active[CTL_FUNC_BIT];
  assign host_irq     = core_irq_in & core_irq_en & core_func_en;

endmodule

// File: rtl/seg_core_window.sv
module seg_core_window
  import segwin_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int HOST_OFF_W = 12,
  parameter int WIN_W      = 11,
  parameter int BP_AW      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [7:0]            cfg_addr,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  input  logic                  sel_alt_ctl,
  input  logic                  host_req_valid,
  output logic                  host_req_ready,
  input  logic                  host_req_write,
  input  logic [HOST_OFF_W-1:0] host_req_off,
  input  logic [DATA_W-1:0]     host_req_wdata,
  output logic                  host_rsp_valid,
  input  logic                  host_rsp_ready,
  output logic [DATA_W-1:0]     host_rsp_rdata,
  output logic                  bp_req_valid,
  input  logic                  bp_req_ready,
  output logic                  bp_req_write,
  output logic [BP_AW-1:0]      bp_req_addr,
  output logic [DATA_W-1:0]     bp_req_wdata,
  input  logic                  bp_rsp_valid,
  input  logic [DATA_W-1:0]     bp_rsp_rdata,
  input  logic                  core_irq_in,
  output logic                  host_irq,
  output logic                  core_reset,
  output logic                  core_irq_en,
  output logic                  core_func_en
);

  logic [CFG_DW-1:0] ctl_q;
  logic [CFG_DW-1:0] alt_q;
  win_base_t         base;
  logic [BP_AW-1:0]  xl_addr;
  logic              in_window;

  segwin_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .ctl_q     (ctl_q),
    .alt_q     (alt_q),
    .base      (base)
  );

  segwin_xlate #(
    .HOST_OFF_W (HOST_OFF_W),
    .WIN_W      (WIN_W),
    .BP_AW      (BP_AW)
  ) u_xlate (
    .base      (base),
    .off       (host_req_off),
    .bp_addr   (xl_addr),
    .in_window (in_window)
  );

  segwin_txn_fsm #(
    .DATA_W (DATA_W),
    .BP_AW  (BP_AW)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_req_valid (host_req_valid),
    .host_req_ready (host_req_ready),
    .host_req_write (host_req_write),
    .host_req_wdata (host_req_wdata),
    .in_window      (in_window),
    .xl_addr        (xl_addr),
    .host_rsp_valid (host_rsp_valid),
    .host_rsp_ready (host_rsp_ready),
    .host_rsp_rdata (host_rsp_rdata),
    .bp_req_valid   (bp_req_valid),
    .bp_req_ready   (bp_req_ready),
    .bp_req_write   (bp_req_write),
    .bp_req_addr    (bp_req_addr),
    .bp_req_wdata   (bp_req_wdata),
    .bp_rsp_valid   (bp_rsp_valid),
    .bp_rsp_rdata   (bp_rsp_rdata)
  );

  segwin_ctl_out u_ctl (
    .ctl_q        (ctl_q),
    .alt_q        (alt_q),
    .sel_alt      (sel_alt_ctl),
    .core_irq_in  (core_irq_in),
    .core_reset   (core_reset),
    .core_irq_en  (core_irq_en),
    .core_func_en (core_func_en),
    .host_irq     (host_irq)
  );

endmodule

// File: rtl/segwin_checker.sv
module segwin_checker
  import segwin_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int HOST_OFF_W = 12,
  parameter int WIN_W      = 11,
  parameter int BP_AW      = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_wr,
  input logic [7:0]            cfg_addr,
  input logic [7:0]            cfg_wdata,
  input logic                  sel_alt_ctl,
  input logic                  host_req_valid,
  input logic                  host_req_ready,
  input logic [HOST_OFF_W-1:0] host_req_off,
  input logic                  host_rsp_valid,
  input logic                  host_rsp_ready,
  input logic [DATA_W-1:0]     host_rsp_rdata,
  input logic                  bp_req_valid,
  input logic                  bp_req_ready,
  input logic                  bp_req_write,
  input logic [BP_AW-1:0]      bp_req_addr,
  input logic [DATA_W-1:0]     bp_req_wdata,
  input logic                  bp_rsp_valid,
  input logic                  core_irq_in,
  input logic                  host_irq,
  input logic                  core_reset,
  input logic                  core_irq_en,
  input logic                  core_func_en
);

  logic host_fire;
  assign host_fire = host_req_valid && host_req_ready;

  // R1: outputs in reset state while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (core_reset && !core_irq_en && !core_func_en && !host_irq);
    end
  end

  p_ctl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == OFF_CTL && !sel_alt_ctl) |=>
      (sel_alt_ctl || (core_reset == $past(cfg_wdata[7]) &&
                       core_irq_en == $past(cfg_wdata[2]) &&
                       core_func_en == $past(cfg_wdata[0]))));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (core_irq_in && core_irq_en && core_func_en));

  p_addr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_fire && host_req_off[HOST_OFF_W-1:WIN_W] == '0) |=>
      (bp_req_valid && bp_req_addr[WIN_W-1:0] == $past(host_req_off[WIN_W-1:0])));

  p_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_fire && host_req_off[HOST_OFF_W-1:WIN_W] != '0) |=>
      (!bp_req_valid && host_rsp_valid && host_rsp_rdata == '0));

  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_ready |-> (!bp_req_valid && !host_rsp_valid));

  p_bp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_req_valid && !bp_req_ready) |=>
      (bp_req_valid && $stable(bp_req_addr) && $stable(bp_req_write) && $stable(bp_req_wdata)));

  p_bp_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_req_valid && bp_req_ready) |=> !bp_req_valid);

  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && !host_rsp_ready) |=> (host_rsp_valid && $stable(host_rsp_rdata)));

  p_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_ready && bp_rsp_valid && !host_req_valid) |=> !host_rsp_valid);

endmodule

bind seg_core_window segwin_checker #(
  .DATA_W     (DATA_W),
  .HOST_OFF_W (HOST_OFF_W),
  .WIN_W      (WIN_W),
  .BP_AW      (BP_AW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_wr         (cfg_wr),
  .cfg_addr       (cfg_addr),
  .cfg_wdata      (cfg_wdata),
  .sel_alt_ctl    (sel_alt_ctl),
  .host_req_valid (host_req_valid),
  .host_req_ready (host_req_ready),
  .host_req_off   (host_req_off),
  .host_rsp_valid (host_rsp_valid),
  .host_rsp_ready (host_rsp_ready),
  .host_rsp_rdata (host_rsp_rdata),
  .bp_req_valid   (bp_req_valid),
  .bp_req_ready   (bp_req_ready),
  .bp_req_write   (bp_req_write),
  .bp_req_addr    (bp_req_addr),
  .bp_req_wdata   (bp_req_wdata),
  .bp_rsp_valid   (bp_rsp_valid),
  .core_irq_in    (core_irq_in),
  .host_irq       (host_irq),
  .core_reset     (core_reset),
  .core_irq_en    (core_irq_en),
  .core_func_en   (core_func_en)
);

// File: tb/seg_core_window_test.sv
module seg_core_window_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        sel_alt_ctl = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_write = 1'b0;
  logic [11:0] host_req_off = '0;
  logic [31:0] host_req_wdata = '0;
  logic        host_rsp_valid;
  logic        host_rsp_ready = 1'b0;
  logic [31:0] host_rsp_rdata;
  logic        bp_req_valid;
  logic        bp_req_ready = 1'b0;
  logic        bp_req_write;
  logic [31:0] bp_req_addr;
  logic [31:0] bp_req_wdata;
  logic        bp_rsp_valid = 1'b0;
  logic [31:0] bp_rsp_rdata = '0;
  logic        core_irq_in = 1'b0;
  logic        host_irq;
  logic        core_reset;
  logic        core_irq_en;
  logic        core_func_en;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench copy of the register bank, from R2
  logic [7:0] m_ctl, m_alt, m_s0, m_s1, m_s2;
  logic       m_seg;

  always #10 clk = ~clk;

  seg_core_window uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_ctl;
      8'h80:   return m_alt;
      8'h2E:   return m_s0;
      8'h30:   return m_s1;
      8'h32:   return m_s2;
      8'h34:   return {7'b0, m_seg};
      default: return 8'h00;
    endcase
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    case (a)
      8'h00: m_ctl = d;
      8'h80: m_alt = d;
      8'h2E: m_s0  = d & 8'h0F;
      8'h30: m_s1  = d;
      8'h32: m_s2  = d;
      8'h34: m_seg = d[0];
      default: ;
    endcase
  endtask

  function automatic logic [31:0] bp_answer(input logic [31:0] a);
    return a ^ 32'hC3C3_0F0F;
  endfunction

  task automatic host_txn(input bit w, input logic [11:0] off, input logic [31:0] wd,
                          input int rlat, input int plat, input int hold);
    logic [31:0] exp_addr;
    logic [31:0] exp_data;
    bit          inwin;
    inwin    = (off < 12'h800);
    exp_addr = {m_s2, m_s1, m_s0[3:0], m_seg, off[10:0]};
    exp_data = (inwin && !w) ? bp_answer(exp_addr) : 32'h0;
    check(host_req_ready == 1'b1, "R5 ready when idle", {31'b0, host_req_ready}, 32'h1);
    host_req_valid = 1'b1; host_req_write = w; host_req_off = off; host_req_wdata = wd;
    @(negedge clk);
    host_req_valid = 1'b0;
    check(host_req_ready == 1'b0, "R5 busy after accept", {31'b0, host_req_ready}, 32'h0);
    if (inwin) begin
      check(bp_req_valid && bp_req_addr == exp_addr, "R3 backplane address", bp_req_addr, exp_addr);
      check(bp_req_write == w && bp_req_wdata == wd, "R6 write flag and data", bp_req_wdata, wd);
      for (int k = 0; k < rlat; k++) begin
        bp_rsp_valid = 1'b1;  // stray answer before acceptance, R10
        @(negedge clk);
        bp_rsp_valid = 1'b0;
        check(bp_req_valid && bp_req_addr == exp_addr, "R6 request held", bp_req_addr, exp_addr);
        check(!host_rsp_valid, "R10 stray answer ignored", {31'b0, host_rsp_valid}, 32'h0);
      end
      bp_req_ready = 1'b1;
      @(negedge clk);
      bp_req_ready = 1'b0;
      check(!bp_req_valid, "R6 request drops after ready", {31'b0, bp_req_valid}, 32'h0);
      for (int k = 0; k < plat; k++) begin
        @(negedge clk);
        check(!host_rsp_valid, "R7 no response before answer", {31'b0, host_rsp_valid}, 32'h0);
      end
      bp_rsp_valid = 1'b1; bp_rsp_rdata = bp_answer(exp_addr);
      @(negedge clk);
      bp_rsp_valid = 1'b0; bp_rsp_rdata = '0;
      check(host_rsp_valid && host_rsp_rdata == exp_data, "R7 response data", host_rsp_rdata, exp_data);
    end else begin
      check(!bp_req_valid, "R4 no backplane request", {31'b0, bp_req_valid}, 32'h0);
      check(host_rsp_valid && host_rsp_rdata == 32'h0, "R4 zero response", host_rsp_rdata, 32'h0);
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(host_rsp_valid && host_rsp_rdata == exp_data, "R7 response held", host_rsp_rdata, exp_data);
    end
    host_rsp_ready = 1'b1;
    @(negedge clk);
    host_rsp_ready = 1'b0;
    check(!host_rsp_valid && host_req_ready, "R5 idle after response", {31'b0, host_req_ready}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    m_ctl = 8'h80; m_alt = 8'h80; m_s0 = 0; m_s1 = 0; m_s2 = 0; m_seg = 0;
    #5 rst_n = 1'b0;
    @(negedge clk);
    // R1: state during reset
    check(core_reset && !core_irq_en && !core_func_en, "R1 outputs in reset",
          {29'b0, core_reset, core_irq_en, core_func_en}, 32'h4);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (v[i]) ;
    for (int a = 0; a < 256; a++) begin
      cfg_addr = 8'(a); #1;
      check(cfg_rdata == model_read(8'(a)), "R1 register reset value", {24'b0, cfg_rdata},
            {24'b0, model_read(8'(a))});
    end
    check(core_reset && !core_irq_en && !core_func_en && host_req_ready, "R1 outputs after reset",
          {29'b0, core_reset, core_irq_en, core_func_en}, 32'h4);
    @(negedge clk);

    // R2: write every offset, then read every offset back
    for (int a = 0; a < 256; a++) cfg_write(8'(a), 8'(a) ^ 8'h5A);
    for (int a = 0; a < 256; a++) begin
      cfg_addr = 8'(a); #1;
      check(cfg_rdata == model_read(8'(a)), "R2 readback", {24'b0, cfg_rdata},
            {24'b0, model_read(8'(a))});
    end
    @(negedge clk);

    // R8: every control value through each selector setting
    for (int s = 0; s < 2; s++) begin
      for (int x = 0; x < 256; x++) begin
        v = 8'(x);
        sel_alt_ctl = s[0];
        cfg_write(s ? 8'h80 : 8'h00, v);
        cfg_write(s ? 8'h00 : 8'h80, ~v);
        check(core_reset == v[7] && core_irq_en == v[2] && core_func_en == v[0],
              "R8 control decode", {29'b0, core_reset, core_irq_en, core_func_en},
              {29'b0, v[7], v[2], v[0]});
      end
    end

    // R9: interrupt forwarding over all gate combinations
    for (int c = 0; c < 16; c++) begin
      sel_alt_ctl = c[3];
      cfg_write(8'h00, {5'b0, c[1], 1'b0, c[0]});
      cfg_write(8'h80, {5'b0, c[1], 1'b0, c[0]} ^ 8'h05);
      core_irq_in = c[2];
      #1;
      check(host_irq == (c[2] && (c[3] ? !c[1] && !c[0] : c[1] && c[0])), "R9 irq gating",
            {31'b0, host_irq}, {31'b0, c[2] && (c[3] ? !c[1] && !c[0] : c[1] && c[0])});
      @(negedge clk);
    end
    core_irq_in = 1'b0;
    sel_alt_ctl = 1'b0;

    // R10: stray answer while idle
    bp_rsp_valid = 1'b1; bp_rsp_rdata = 32'hDEAD_BEEF;
    @(negedge clk);
    bp_rsp_valid = 1'b0; bp_rsp_rdata = '0;
    check(!host_rsp_valid && host_req_ready, "R10 idle stray answer ignored",
          {31'b0, host_rsp_valid}, 32'h0);

    // R3/R4/R6/R7: sweep of core selection, segment and window offsets
    begin
      int n = 0;
      logic [11:0] offs [6] = '{12'h000, 12'h004, 12'h123, 12'h7FF, 12'h800, 12'hFFC};
      for (int a0 = 0; a0 < 16; a0++) begin
        for (int sg = 0; sg < 2; sg++) begin
          cfg_write(8'h2E, 8'(a0) | 8'hA0);
          cfg_write(8'h30, 8'(a0 * 17));
          cfg_write(8'h32, ~8'(a0 * 13));
          cfg_write(8'h34, {7'b1010101, sg[0]});
          for (int o = 0; o < 6; o++) begin
            host_txn(n[0], offs[o], 32'h1000_0000 + 32'(n), n % 3, n % 2, (n / 2) % 2);
            n++;
          end
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule